// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block keeps the control state of every resident warp (program counter, active lane mask, stall flag and a small divergence stack) in registers of its own and, in each clock cycle, picks one ready warp and issues one instruction for all of that warp's active lanes. Picking another warp costs no cycles because nothing is saved or restored. A warp that issues a long-latency memory operation stays parked until a completion event names it. While it waits, the other resident warps take its issue slots.

The scheduler shows the picked warp's program counter. Fetch and decode outside the block return the instruction's kind in the same cycle, and for a branch they also return the per-lane taken vector, the branch target and the reconvergence address. A branch whose lanes disagree is split into two masked passes: taken lanes first, then the not-taken lanes. The full mask comes back at the reconvergence address. Warps are brought in and taken out through separate allocate and free ports.

Top module: `warp_issue_sched`

## Requirements
- R1: Each cycle with at least one ready warp, `iss_valid` is 1 and `iss_warp`, `iss_pc` and `iss_mask` give that warp's id, program counter and active lanes. A warp is ready when it is resident, not stalled and not exited.
- R2: The ready warp is chosen round-robin. The search starts at the warp after the one issued most recently. After reset the search starts at warp 0.
- R3: With no ready warp the cycle is a bubble: `iss_valid` is 0, `idle` is 1, and `iss_warp`, `iss_pc` and `iss_mask` are 0.
- R4: Kind code 1 (memory) advances the pc by one and stalls the warp. A stalled warp is not issued until `mem_done_valid` names it, and it can issue in the cycle right after that event. A completion for a warp that is not stalled has no effect.
- R5: Kind code 0 (arithmetic) advances the pc by one. Kind code 3 (exit) leaves the pc unchanged, and the warp is never issued again until it is freed.
- R6: Kind code 2 is a branch, and the taken set is `br_taken` AND the active mask. If the taken set is empty the pc advances by one. If it equals the whole active mask the pc becomes `br_target`. In both cases the mask is unchanged.
- R7: A divergent branch (taken set neither empty nor full) pushes a stack entry. The taken lanes run from `br_target`. When the next pc equals the entry's `br_reconv`, the not-taken lanes run from the branch pc plus one. When the next pc equals `br_reconv` again, the entry is popped and the earlier mask resumes at that pc. Divergence may nest up to STACK_DEPTH levels.
- R8: `alloc_valid` makes a non-resident warp resident with pc `alloc_pc`, mask `alloc_mask`, not stalled, not exited and with an empty stack. An allocation to a warp that is already resident is ignored.
- R9: `free_valid` removes the warp and clears its stall, exit and stack. When it meets an allocation or an issue to the same warp in the same cycle, the free wins.
- R10: After reset no warp is resident and the scheduler is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Allocate a warp this cycle |
| alloc_id | input | WID_W (6) | Warp to allocate |
| alloc_pc | input | PC_W (16) | Starting program counter |
| alloc_mask | input | LANES (32) | Initial active lanes |
| free_valid | input | 1 | Free a warp this cycle |
| free_id | input | WID_W (6) | Warp to free |
| iss_kind | input | 2 | Kind of the issued instruction: 0 arithmetic, 1 memory, 2 branch, 3 exit |
| br_taken | input | LANES (32) | Per-lane branch outcome |
| br_target | input | PC_W (16) | Branch target address |
| br_reconv | input | PC_W (16) | Reconvergence address of a branch |
| mem_done_valid | input | 1 | A memory access completed |
| mem_done_id | input | WID_W (6) | Warp whose access completed |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_warp | output | WID_W (6) | Issued warp id |
| iss_pc | output | PC_W (16) | Issued program counter |
| iss_mask | output | LANES (32) | Lanes that execute the instruction |
| idle | output | 1 | Bubble cycle, no warp ready |

## Verification
The assertions check, on every cycle, that the bubble and the ready set agree, that only ready warps issue, that a warp which issued a memory operation does not issue in the next cycle, that a completion releases its warp on the following edge, that a free empties the warp slot, and that a push never meets a full stack. Round-robin order, the pc arithmetic, and the order of masked passes with reconvergence and mask restore can only be shown by the bench. Its reference model runs a small program with divergent, uniform-taken and uniform-not-taken branches on several warps and compares every issue slot against the model.

// File: rtl/wsched_pkg.sv
// Shared types of the warp issue scheduler.
// Assumes: the decode side encodes the instruction kind on two bits.
package wsched_pkg;

    typedef enum logic [1:0] {
        K_ALU  = 2'd0,
        K_MEM  = 2'd1,
        K_BRA  = 2'd2,
        K_EXIT = 2'd3
    } kind_e;

endpackage

// File: rtl/wsched_div_stack.sv
// Divergence stack of one warp. Each entry holds the reconvergence pc,
// the pc and mask of the pending not-taken pass, the mask before the split
// and a phase bit (0: taken pass running, 1: not-taken pass running).
// Assumes: push, to_else and pop never coincide; DEPTH >= 2.
module wsched_div_stack #(
    parameter int PC_W  = 16,
    parameter int LANES = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [PC_W-1:0]  push_rc,
    input  logic [PC_W-1:0]  push_epc,
    input  logic [LANES-1:0] push_emask,
    input  logic [LANES-1:0] push_omask,
    input  logic             to_else,
    input  logic             pop,
    output logic             top_valid,
    output logic             top_else,
    output logic [PC_W-1:0]  top_rc,
    output logic [PC_W-1:0]  top_epc,
    output logic [LANES-1:0] top_emask,
    output logic [LANES-1:0] top_omask,
    output logic             full
);

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [SP_W-1:0]  sp_q;
    logic [DEPTH-1:0] ph_q;
    logic [PC_W-1:0]  rc_q    [DEPTH];
    logic [PC_W-1:0]  epc_q   [DEPTH];
    logic [LANES-1:0] emask_q [DEPTH];
    logic [LANES-1:0] omask_q [DEPTH];

    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             do_push;

    // Index of the top entry and of the next free slot.
    always_comb begin
        top_idx = IDX_W'(sp_q - SP_W'(1));
        wr_idx  = IDX_W'(sp_q);
        full    = (sp_q == SP_W'(DEPTH));
        do_push = push && !full && !clr;
    end

    // Top-of-stack view.
    always_comb begin
        top_valid = (sp_q != '0);
        top_else  = ph_q[top_idx];
        top_rc    = rc_q[top_idx];
        top_epc   = epc_q[top_idx];
        top_emask = emask_q[top_idx];
        top_omask = omask_q[top_idx];
    end

    // Stack pointer and phase bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            ph_q <= '0;
        end else if (clr) begin
            sp_q <= '0;
        end else if (do_push) begin
            sp_q          <= sp_q + SP_W'(1);
            ph_q[wr_idx]  <= 1'b0;
        end else if (to_else && top_valid) begin
            ph_q[top_idx] <= 1'b1;
        end else if (pop && top_valid) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end

    // Entry payload, written only on a push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            rc_q[wr_idx]    <= push_rc;
            epc_q[wr_idx]   <= push_epc;
            emask_q[wr_idx] <= push_emask;
            omask_q[wr_idx] <= push_omask;
        end
    end

endmodule

// File: rtl/wsched_warp_ctx.sv
// Resident context of one warp: pc, active mask, stall and exit flags
// plus its divergence stack. Applies the effect of an issued instruction
// at the clock edge that closes the issue cycle.
// Assumes: a taken path never starts at its own reconvergence pc, and
// nested branches use distinct reconvergence pcs.
module wsched_warp_ctx
    import wsched_pkg::*;
#(
    parameter int PC_W        = 16,
    parameter int LANES       = 32,
    parameter int STACK_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [PC_W-1:0]  alloc_pc_i,
    input  logic [LANES-1:0] alloc_mask_i,
    input  logic             free_i,
    input  logic             issue_i,
    input  kind_e            kind_i,
    input  logic [LANES-1:0] br_taken_i,
    input  logic [PC_W-1:0]  br_target_i,
    input  logic [PC_W-1:0]  br_reconv_i,
    input  logic             mem_done_i,
    output logic             ready_o,
    output logic             resident_o,
    output logic             stalled_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [LANES-1:0] mask_o,
    output logic             push_o,
    output logic             full_o
);

    logic             resident_q, stalled_q, exited_q;
    logic [PC_W-1:0]  pc_q;
    logic [LANES-1:0] mask_q;

    logic             act, diverge, hit, to_else, pop, clr;
    logic [LANES-1:0] taken;
    logic [PC_W-1:0]  pc_inc, npc_raw, npc;
    logic [LANES-1:0] nmask;

    logic             top_valid, top_else;
    logic [PC_W-1:0]  top_rc, top_epc;
    logic [LANES-1:0] top_emask, top_omask;

    // Issue takes effect only if the warp is not freed in the same cycle.
    always_comb begin
        act     = issue_i && !free_i;
        taken   = br_taken_i & mask_q;
        pc_inc  = pc_q + PC_W'(1);
        diverge = act && (kind_i == K_BRA) && (taken != '0) && (taken != mask_q);
        clr     = free_i || (alloc_i && !resident_q);
    end

    // Next pc before any reconvergence action.
    always_comb begin
        unique case (kind_i)
            K_ALU, K_MEM: npc_raw = pc_inc;
            K_BRA:        npc_raw = (taken == '0) ? pc_inc : br_target_i;
            default:      npc_raw = pc_q;
        endcase
    end

    // Reconvergence: switch to the pending pass or restore the mask.
    always_comb begin
        hit     = act && !diverge && (kind_i != K_EXIT) && top_valid && (npc_raw == top_rc);
        to_else = hit && !top_else;
        pop     = hit && top_else;
        npc     = to_else ? top_epc : npc_raw;
        if (to_else)      nmask = top_emask;
        else if (pop)     nmask = top_omask;
        else if (diverge) nmask = taken;
        else              nmask = mask_q;
    end

    // Warp state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resident_q <= 1'b0;
            stalled_q  <= 1'b0;
            exited_q   <= 1'b0;
            pc_q       <= '0;
            mask_q     <= '0;
        end else if (free_i) begin
            resident_q <= 1'b0;
            stalled_q  <= 1'b0;
            exited_q   <= 1'b0;
        end else if (alloc_i && !resident_q) begin
            resident_q <= 1'b1;
            stalled_q  <= 1'b0;
            exited_q   <= 1'b0;
            pc_q       <= alloc_pc_i;
            mask_q     <= alloc_mask_i;
        end else begin
            if (act) begin
                pc_q   <= npc;
                mask_q <= nmask;
                if (kind_i == K_MEM)  stalled_q <= 1'b1;
                if (kind_i == K_EXIT) exited_q  <= 1'b1;
            end
            if (mem_done_i && stalled_q) stalled_q <= 1'b0;
        end
    end

    wsched_div_stack #(
        .PC_W  (PC_W),
        .LANES (LANES),
        .DEPTH (STACK_DEPTH)
    ) i_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .push       (diverge),
        .push_rc    (br_reconv_i),
        .push_epc   (pc_inc),
        .push_emask (mask_q & ~taken),
        .push_omask (mask_q),
        .to_else    (to_else),
        .pop        (pop),
        .top_valid  (top_valid),
        .top_else   (top_else),
        .top_rc     (top_rc),
        .top_epc    (top_epc),
        .top_emask  (top_emask),
        .top_omask  (top_omask),
        .full       (full_o)
    );

    // Status seen by the picker and the checker.
    always_comb begin
        ready_o    = resident_q && !stalled_q && !exited_q;
        resident_o = resident_q;
        stalled_o  = stalled_q;
        pc_o       = pc_q;
        mask_o     = mask_q;
        push_o     = diverge;
    end

endmodule

// File: rtl/wsched_rr_pick.sv
// Round-robin picker over the ready vector. The search begins one past
// the last granted index; the pointer moves only when a grant is made.
// Assumes: N fits in ID_W bits.
module wsched_rr_pick #(
    parameter int N    = 64,
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    output logic            gnt_valid,
    output logic [ID_W-1:0] gnt_id
);

    logic [ID_W-1:0] last_q;

    // Scan from farthest to nearest so the nearest ready warp wins.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_id    = '0;
        for (int k = N; k >= 1; k--) begin
            if (req[(int'(last_q) + k) % N]) begin
                gnt_valid = 1'b1;
                gnt_id    = ID_W'((int'(last_q) + k) % N);
            end
        end
    end

    // Remember the most recent grant.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= ID_W'(N - 1);
        else if (gnt_valid) last_q <= gnt_id;
    end

endmodule

// File: rtl/warp_issue_sched.sv
// Warp issue scheduler: one instruction per cycle from a ready warp,
// zero-cost switching between resident warps, memory stalls released by
// completion events, and masked two-pass execution of divergent branches.
// Assumes: iss_kind and the branch inputs describe the instruction at
// iss_pc of iss_warp within the same cycle.
module warp_issue_sched
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS   = 64,
    parameter int LANES       = 32,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 4,
    localparam int WID_W      = $clog2(NUM_WARPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [WID_W-1:0] alloc_id,
    input  logic [PC_W-1:0]  alloc_pc,
    input  logic [LANES-1:0] alloc_mask,
    input  logic             free_valid,
    input  logic [WID_W-1:0] free_id,
    input  logic [1:0]       iss_kind,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             mem_done_valid,
    input  logic [WID_W-1:0] mem_done_id,
    output logic             iss_valid,
    output logic [WID_W-1:0] iss_warp,
    output logic [PC_W-1:0]  iss_pc,
    output logic [LANES-1:0] iss_mask,
    output logic             idle
);

    logic [NUM_WARPS-1:0] ready_vec, resident_vec, stalled_vec, push_vec, full_vec;
    logic [PC_W-1:0]      pc_arr   [NUM_WARPS];
    logic [LANES-1:0]     mask_arr [NUM_WARPS];
    logic                 gnt_valid;
    logic [WID_W-1:0]     gnt_id;
    kind_e                kind;

    // Decode the two-bit kind into the shared enum.
    always_comb kind = kind_e'(iss_kind);

    wsched_rr_pick #(
        .N    (NUM_WARPS),
        .ID_W (WID_W)
    ) i_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ready_vec),
        .gnt_valid (gnt_valid),
        .gnt_id    (gnt_id)
    );

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        wsched_warp_ctx #(
            .PC_W        (PC_W),
            .LANES       (LANES),
            .STACK_DEPTH (STACK_DEPTH)
        ) i_ctx (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (alloc_valid && (alloc_id == WID_W'(w))),
            .alloc_pc_i   (alloc_pc),
            .alloc_mask_i (alloc_mask),
            .free_i       (free_valid && (free_id == WID_W'(w))),
            .issue_i      (gnt_valid && (gnt_id == WID_W'(w))),
            .kind_i       (kind),
            .br_taken_i   (br_taken),
            .br_target_i  (br_target),
            .br_reconv_i  (br_reconv),
            .mem_done_i   (mem_done_valid && (mem_done_id == WID_W'(w))),
            .ready_o      (ready_vec[w]),
            .resident_o   (resident_vec[w]),
            .stalled_o    (stalled_vec[w]),
            .pc_o         (pc_arr[w]),
            .mask_o       (mask_arr[w]),
            .push_o       (push_vec[w]),
            .full_o       (full_vec[w])
        );
    end

    // Issue port: picked warp's state, or an all-zero bubble.
    always_comb begin
        iss_valid = gnt_valid;
        iss_warp  = gnt_id;
        iss_pc    = gnt_valid ? pc_arr[gnt_id]   : '0;
        iss_mask  = gnt_valid ? mask_arr[gnt_id] : '0;
        idle      = !gnt_valid;
    end

endmodule

// File: rtl/wsched_chk.sv
// Protocol checker for the warp issue scheduler, bound to the top module.
// Assumes: it sees the per-warp status vectors of the top module.
module wsched_chk #(
    parameter int NUM_WARPS = 64,
    parameter int LANES     = 32,
    parameter int WID_W     = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_valid,
    input logic [WID_W-1:0]     iss_warp,
    input logic [LANES-1:0]     iss_mask,
    input logic                 idle,
    input logic [1:0]           iss_kind,
    input logic                 mem_done_valid,
    input logic [WID_W-1:0]     mem_done_id,
    input logic                 free_valid,
    input logic [WID_W-1:0]     free_id,
    input logic [NUM_WARPS-1:0] ready_vec,
    input logic [NUM_WARPS-1:0] resident_vec,
    input logic [NUM_WARPS-1:0] stalled_vec,
    input logic [NUM_WARPS-1:0] push_vec,
    input logic [NUM_WARPS-1:0] full_vec
);

    // R3
    bubble_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!iss_valid && iss_mask == '0 && ready_vec == '0));

    // R1
    issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (resident_vec[iss_warp] && !stalled_vec[iss_warp]));

    // R4
    mem_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_kind == 2'd1) |=> !(iss_valid && iss_warp == $past(iss_warp)));

    // R4
    mem_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_done_valid && stalled_vec[mem_done_id]) |=> !stalled_vec[$past(mem_done_id)]);

    // R9
    free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |=> !resident_vec[$past(free_id)]);

    // R7
    stack_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vec & full_vec) == '0);

endmodule

bind warp_issue_sched wsched_chk #(
    .NUM_WARPS (NUM_WARPS),
    .LANES     (LANES),
    .WID_W     (WID_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_valid      (iss_valid),
    .iss_warp       (iss_warp),
    .iss_mask       (iss_mask),
    .idle           (idle),
    .iss_kind       (iss_kind),
    .mem_done_valid (mem_done_valid),
    .mem_done_id    (mem_done_id),
    .free_valid     (free_valid),
    .free_id        (free_id),
    .ready_vec      (ready_vec),
    .resident_vec   (resident_vec),
    .stalled_vec    (stalled_vec),
    .push_vec       (push_vec),
    .full_vec       (full_vec)
);

// File: tb/test_warp_issue_sched.sv
// Bench: behavioural reference model compared on every clock.
module test_warp_issue_sched;

    localparam int NW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [5:0]  alloc_id = '0;
    logic [15:0] alloc_pc = '0;
    logic [31:0] alloc_mask = '0;
    logic        free_valid = 1'b0;
    logic [5:0]  free_id = '0;
    logic [1:0]  iss_kind;
    logic [31:0] br_taken;
    logic [15:0] br_target, br_reconv;
    logic        mem_done_valid = 1'b0;
    logic [5:0]  mem_done_id = '0;
    logic        iss_valid, idle;
    logic [5:0]  iss_warp;
    logic [15:0] iss_pc;
    logic [31:0] iss_mask;

    int n_chk = 0, n_fail = 0, cyc = 0;
    string cur_req = "R10";

    always #2 clk = ~clk;

    warp_issue_sched i_warp_issue_sched (.*);

    // Test program, shared by stimulus and model.
    function automatic logic [1:0] prog_kind(input logic [15:0] p);
        case (p)
            16'd1, 16'd9, 16'd22: return 2'd2;
            16'd3, 16'd20:        return 2'd1;
            16'd24:               return 2'd3;
            default:              return 2'd0;
        endcase
    endfunction
    function automatic logic [31:0] prog_taken(input logic [15:0] p);
        case (p)
            16'd1:   return 32'h00FF_FFFF;
            16'd9:   return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction
    function automatic logic [15:0] prog_tgt(input logic [15:0] p);
        case (p)
            16'd1:   return 16'd10;
            16'd9:   return 16'd20;
            default: return 16'd30;
        endcase
    endfunction

    always_comb begin
        iss_kind  = prog_kind(iss_pc);
        br_taken  = prog_taken(iss_pc);
        br_target = prog_tgt(iss_pc);
        br_reconv = 16'd20;
    end

    // Reference model state.
    bit          m_res[NW], m_stl[NW], m_ext[NW];
    logic [15:0] m_pc[NW];
    logic [31:0] m_mask[NW];
    int          m_sp[NW];
    logic [15:0] m_rc[NW][4], m_ep[NW][4];
    logic [31:0] m_em[NW][4], m_om[NW][4];
    bit          m_ph[NW][4];
    int          m_last = NW - 1;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit m_ready(input int w);
        return m_res[w] && !m_stl[w] && !m_ext[w];
    endfunction

    task automatic model_issue(input int w);
        logic [1:0]  k = prog_kind(m_pc[w]);
        logic [31:0] t = prog_taken(m_pc[w]) & m_mask[w];
        logic [15:0] np;
        logic [31:0] nm = m_mask[w];
        bit div = 0;
        int s;
        np = m_pc[w] + 16'd1;
        if (k == 2'd1) m_stl[w] = 1;
        if (k == 2'd3) begin m_ext[w] = 1; np = m_pc[w]; end
        if (k == 2'd2) begin
            if (t == 0) np = m_pc[w] + 16'd1;
            else if (t == m_mask[w]) np = prog_tgt(m_pc[w]);
            else begin
                s = m_sp[w];
                m_rc[w][s] = 16'd20; m_ep[w][s] = m_pc[w] + 16'd1;
                m_em[w][s] = m_mask[w] & ~t; m_om[w][s] = m_mask[w]; m_ph[w][s] = 0;
                m_sp[w] = s + 1; nm = t; np = prog_tgt(m_pc[w]); div = 1;
            end
        end
        if (!div && k != 2'd3 && m_sp[w] > 0 && np == m_rc[w][m_sp[w]-1]) begin
            s = m_sp[w] - 1;
            if (!m_ph[w][s]) begin m_ph[w][s] = 1; np = m_ep[w][s]; nm = m_em[w][s]; end
            else begin m_sp[w] = s; nm = m_om[w][s]; end
        end
        m_pc[w] = np; m_mask[w] = nm;
    endtask

    // One cycle: compare outputs, advance the model, clear pulses.
    task automatic tick();
        int w = -1;
        bit old_stl;
        #1;
        for (int k = 1; k <= NW; k++)
            if (w < 0 && m_ready((m_last + k) % NW)) w = (m_last + k) % NW;
        if (w < 0) begin
            chk("R3", "iss_valid", 64'(iss_valid), 64'd0);
            chk("R3", "idle", 64'(idle), 64'd1);
            chk("R3", "bubble fields", {iss_pc, iss_mask, 10'd0, iss_warp}, 64'd0);
        end else begin
            chk("R1", "iss_valid", 64'(iss_valid), 64'd1);
            chk("R2", "iss_warp", 64'(iss_warp), 64'(w));
            chk(cur_req, "iss_pc", 64'(iss_pc), 64'(m_pc[w]));
            chk(cur_req, "iss_mask", 64'(iss_mask), 64'(m_mask[w]));
        end
        old_stl = mem_done_valid ? m_stl[mem_done_id] : 0;
        if (w >= 0) begin
            m_last = w;
            if (!(free_valid && free_id == 6'(w))) model_issue(w);
        end
        if (mem_done_valid && old_stl) m_stl[mem_done_id] = 0;
        if (alloc_valid && !m_res[alloc_id]) begin
            m_res[alloc_id] = 1; m_stl[alloc_id] = 0; m_ext[alloc_id] = 0;
            m_pc[alloc_id] = alloc_pc; m_mask[alloc_id] = alloc_mask; m_sp[alloc_id] = 0;
        end
        if (free_valid) begin
            m_res[free_id] = 0; m_stl[free_id] = 0; m_ext[free_id] = 0; m_sp[free_id] = 0;
        end
        cyc++;
        @(negedge clk);
        alloc_valid = 0; free_valid = 0; mem_done_valid = 0;
    endtask

    task automatic alloc(input int id, input logic [15:0] pc, input logic [31:0] m);
        alloc_valid = 1; alloc_id = 6'(id); alloc_pc = pc; alloc_mask = m;
        tick();
    endtask

    // Run cycles, waking the lowest stalled warp every third cycle.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            if (cyc % 3 == 0) begin
                for (int w = NW - 1; w >= 0; w--)
                    if (m_stl[w]) begin mem_done_valid = 1; mem_done_id = 6'(w); end
            end
            tick();
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "idle in reset", 64'(idle), 64'd1);
        chk("R10", "iss_valid in reset", 64'(iss_valid), 64'd0);
        rst_n = 1;
        cur_req = "R3"; run(3);
        // R8: allocation, then an ignored re-allocation
        cur_req = "R8"; alloc(5, 16'd0, 32'hFFFF_FFFF);
        alloc(5, 16'd100, 32'h1);
        run(2);
        // R2: several warps share the slots
        cur_req = "R2"; alloc(0, 16'd0, 32'hFFFF_FFFF);
        alloc(1, 16'd20, 32'hF0F0_F0F0);
        alloc(63, 16'd25, 32'h0000_00FF);
        run(6);
        // R6: a mask that makes the branch at pc 1 uniformly taken
        cur_req = "R6"; alloc(2, 16'd1, 32'h0000_FFFF);
        run(8);
        // R4: completion to a warp that is not stalled
        cur_req = "R4"; mem_done_valid = 1; mem_done_id = 6'd63; tick();
        run(10);
        // R7: divergent passes and reconvergence
        cur_req = "R7"; run(40);
        // R9: free a warp, and free one in a cycle where it issues
        cur_req = "R9"; free_valid = 1; free_id = 6'd63; tick();
        chk("R9", "warp 63 gone", 64'(iss_valid && iss_warp == 6'd63), 64'd0);
        run(2);
        // R5: everyone runs to exit
        cur_req = "R5"; run(200);
        chk("R5", "idle after all exited", 64'(idle), 64'd1);
        // R9: exited warps freed and one re-allocated with a fresh stack
        cur_req = "R9";
        foreach (m_res[w]) if (m_res[w]) begin free_valid = 1; free_id = 6'(w); tick(); end
        alloc(7, 16'd0, 32'hFFFF_FFFF);
        free_valid = 1; free_id = 6'd7; tick();
        alloc(7, 16'd0, 32'hFFFF_FFFF);
        cur_req = "R7"; run(80);
        chk("R3", "idle at end", 64'(idle), 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule